// File: doc/BRIEF.md
# Scatter-Gather Descriptor DMA Engine

This block is the bus-master half of a storage device's data path. Software first arms it with a sector count and a direction. It then starts it with the address of a table of region descriptors held in system memory. The engine reads one descriptor at a time. Each descriptor names a memory region by its base address, its byte count and a last-entry marker. The engine moves the region as a series of memory bursts, and no burst ever straddles a memory page. The sector buffer on the device side is the implicit other end of every burst. The direction flag decides whether bursts write system memory (sector buffer to memory) or read it (memory to sector buffer).

A byte budget, derived from the armed sector count, shrinks with every completed burst. When the last descriptor is finished and the budget has reached exactly zero, the engine gives a one-cycle completion pulse to the device state machine. Budget overruns, a budget left over at the end of the table, and aborts all end the command with a one-cycle error pulse instead. While the memory port reports busy, the engine holds off for a fixed number of cycles before it tries again. Before the first burst of each region it waits a fixed access latency plus one cycle per sector in that region.

Top module: `sg_desc_dma`

## Requirements
- R1: While reset is asserted and after its release with no command, `mem_req`, `xfer_done` and `xfer_err` stay low.
- R2: Arming captures a byte budget of `sect_cnt` × 512 bytes, where a `sect_cnt` of 0 stands for 256 sectors.
- R3: The table pointer is `tbl_base` with bits 1:0 forced to zero. The n-th descriptor is fetched as an 8-byte read (`mem_desc`=1, `mem_len`=8) at pointer + 8·n. The response word carries the region base in bits 31:0, the region byte count in bits 47:32 and the last-entry marker in bit 63.
- R4: Each burst length is the smaller of the region bytes left and one page (8192 bytes by default). It is shortened further so that the burst ends exactly at the next page boundary, so address-within-page plus length never exceeds the page size.
- R5: Successive bursts of a region start where the previous one ended, until the region count is used up. The next descriptor is then fetched, unless the finished one carried the last-entry marker.
- R6: `mem_req` is never high while `mem_busy` is high. After a busy attempt, the next attempt comes BACKOFF+1 cycles later.
- R7: After a descriptor response is presented with `mem_ack` in cycle a, the first burst request of that region appears in cycle a + ACC_DELAY + (byte count / 512) + 2, provided the port is not busy.
- R8: When the last-entry region completes with the budget exactly consumed, `xfer_done` pulses for one cycle and no further requests follow.
- R9: When a completing burst is longer than the budget still left (including a budget of zero), or the last-entry region completes with budget left over, `xfer_err` pulses for one cycle and the command ends.
- R10: `abort` while the engine is armed or transferring ends the command with one `xfer_err` pulse and no further requests. `abort` while idle has no effect.
- R11: During burst requests `mem_wr` equals the armed direction flag (1 = sector buffer to memory). During descriptor fetches it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm | input | 1 | Pulse: capture direction and sector count, wait for start |
| dir_to_mem | input | 1 | 1 = sector buffer to memory, 0 = memory to sector buffer |
| sect_cnt | input | 8 | Sector count of the command, 0 means 256 |
| go | input | 1 | Pulse: start walking the table at `tbl_base` |
| tbl_base | input | 32 | Descriptor table address (bits 1:0 ignored) |
| abort | input | 1 | Pulse: cancel the running command |
| mem_req | output | 1 | Memory request, accepted in the cycle it is high |
| mem_desc | output | 1 | Request is a descriptor fetch |
| mem_wr | output | 1 | Request writes system memory |
| mem_addr | output | 32 | Request byte address |
| mem_len | output | 14 | Request byte length |
| mem_busy | input | 1 | Memory port cannot accept a request |
| mem_ack | input | 1 | Completion of the outstanding request |
| mem_rdata | input | 64 | Descriptor word, valid with `mem_ack` of a fetch |
| xfer_done | output | 1 | One-cycle pulse: command finished correctly |
| xfer_err | output | 1 | One-cycle pulse: command ended in error |

## Verification
The bench places regions just below a page boundary, spanning several pages, and exactly filling whole pages. An engine that measured the page room wrongly would issue a burst that straddles a boundary or runs one byte short, and the request-by-request comparison catches the wrong address or length. A sector count of zero has to buy a full 256-sector budget; a design that took it literally would finish with an error instead of the completion pulse. Budget overrun, leftover budget at the last entry, and aborts in the armed and latency phases must each give exactly one error pulse with no stray requests afterwards. Exact cycle counts are checked for the retry spacing under a busy port and for the per-region access latency, which exposes off-by-one counters.

// File: rtl/sgdma_pkg.sv
package sgdma_pkg;

   // Size of one table entry in memory, in bytes.
   localparam int DESC_BYTES = 8;
   // Width of the byte count field inside an entry.
   localparam int CNT_W      = 16;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_ARMED,
      ST_FETCH,
      ST_FWAIT,
      ST_DELAY,
      ST_BURST,
      ST_BWAIT,
      ST_FIN,
      ST_FAIL
   } sg_state_e;

   // Entry layout as returned on the memory read port.
   typedef struct packed {
      logic             last;
      logic [14:0]      rsvd;
      logic [CNT_W-1:0] nbytes;
      logic [31:0]      base;
   } sg_desc_t;

endpackage

// File: rtl/sgdma_span.sv
// Burst length for the current region: bounded by the page size and by
// the distance to the next page boundary.
module sgdma_span #(
   parameter int PAGE_BYTES = 8192,
   parameter int CNT_W      = 16,
   parameter int LEN_W      = 14,
   localparam int PG_W      = $clog2(PAGE_BYTES)
) (
   input  logic [PG_W-1:0]  pg_off,
   input  logic [CNT_W-1:0] left,
   output logic [LEN_W-1:0] len
);

   logic [LEN_W-1:0] room;
   logic [LEN_W-1:0] cap;

   assign room = LEN_W'(PAGE_BYTES) - LEN_W'(pg_off);

   generate
      if (PAGE_BYTES >= (1 << CNT_W)) begin : g_no_clamp
         // A region can never exceed one page: no size clamp needed.
         assign cap = LEN_W'(left);
      end else begin : g_clamp
         assign cap = (left > CNT_W'(PAGE_BYTES)) ? LEN_W'(PAGE_BYTES)
                                                  : LEN_W'(left);
      end
   endgenerate

   assign len = (cap >= room) ? room : cap;

endmodule

// File: rtl/sgdma_retry.sv
// Issue gate for the memory port: while the port is busy, waits a fixed
// number of cycles before trying again.
module sgdma_retry #(
   parameter int BACKOFF = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic want,
   input  logic busy,
   output logic fire
);

   generate
      if (BACKOFF == 0) begin : g_every_cycle
         logic unused_clk;
         assign unused_clk = clk ^ rst_n;
         assign fire = want & ~busy;
      end else begin : g_timer
         localparam int BO_W = $clog2(BACKOFF + 1);
         logic [BO_W-1:0] hold_q;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               hold_q <= '0;
            end else if (!want) begin
               hold_q <= '0;
            end else if (hold_q != '0) begin
               hold_q <= hold_q - 1'b1;
            end else if (busy) begin
               hold_q <= BO_W'(BACKOFF);
            end
         end

         assign fire = want && (hold_q == '0) && !busy;
      end
   endgenerate

endmodule

// File: rtl/sgdma_budget.sv
// Command byte budget: loaded from the sector count, reduced per burst.
module sgdma_budget #(
   parameter int SCNT_W     = 8,
   parameter int SECT_SHIFT = 9,
   parameter int LEN_W      = 14,
   parameter int BUD_W      = 18
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [SCNT_W-1:0] scnt,
   input  logic              take,
   input  logic [LEN_W-1:0]  len,
   output logic [BUD_W-1:0]  left,
   output logic              short_o,
   output logic              exact_o
);

   logic [BUD_W-1:0] sectors;
   logic [BUD_W-1:0] len_ext;

   assign sectors = (scnt == '0) ? BUD_W'(1 << SCNT_W) : BUD_W'(scnt);
   assign len_ext = BUD_W'(len);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         left <= '0;
      end else if (load) begin
         left <= sectors << SECT_SHIFT;
      end else if (take) begin
         left <= left - len_ext;
      end
   end

   assign short_o = left < len_ext;
   assign exact_o = left == len_ext;

   // The budget can only shrink while a command runs; a wrap would grow it.
   assert_no_underflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> left <= $past(left));

endmodule

// File: rtl/sg_desc_dma.sv
module sg_desc_dma
   import sgdma_pkg::*;
#(
   parameter int PAGE_BYTES   = 8192,
   parameter int SECTOR_BYTES = 512,
   parameter int SCNT_W       = 8,
   parameter int BACKOFF      = 4,
   parameter int ACC_DELAY    = 3,
   localparam int LEN_W       = $clog2(PAGE_BYTES) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              arm,
   input  logic              dir_to_mem,
   input  logic [SCNT_W-1:0] sect_cnt,
   input  logic              go,
   input  logic [31:0]       tbl_base,
   input  logic              abort,
   output logic              mem_req,
   output logic              mem_desc,
   output logic              mem_wr,
   output logic [31:0]       mem_addr,
   output logic [LEN_W-1:0]  mem_len,
   input  logic              mem_busy,
   input  logic              mem_ack,
   input  logic [63:0]       mem_rdata,
   output logic              xfer_done,
   output logic              xfer_err
);

   localparam int PG_W       = $clog2(PAGE_BYTES);
   localparam int SECT_SHIFT = $clog2(SECTOR_BYTES);
   localparam int MAX_SECT   = 1 << SCNT_W;
   localparam int BUD_W      = $clog2(MAX_SECT * SECTOR_BYTES) + 1;
   localparam int DLY_W      = $clog2(ACC_DELAY + ((1 << CNT_W) >> SECT_SHIFT) + 1);

   // Elaboration-time parameter checks
   generate
      if ((PAGE_BYTES & (PAGE_BYTES - 1)) != 0) begin : g_bad_page
         $error("PAGE_BYTES must be a power of two");
      end
      if ((SECTOR_BYTES & (SECTOR_BYTES - 1)) != 0) begin : g_bad_sect
         $error("SECTOR_BYTES must be a power of two");
      end
      if (PAGE_BYTES < SECTOR_BYTES) begin : g_small_page
         $error("PAGE_BYTES must hold at least one sector");
      end
      if (BUD_W <= LEN_W) begin : g_small_budget
         $error("budget width must exceed burst length width");
      end
      if (ACC_DELAY < 0 || BACKOFF < 0) begin : g_neg
         $error("delays must not be negative");
      end
   endgenerate

   sg_state_e        st;
   logic [31:0]      tbl_ptr;
   logic [31:0]      rg_addr;
   logic [CNT_W-1:0] rg_left;
   logic             rg_last;
   logic [DLY_W-1:0] dly_q;
   logic             dir_q;
   logic [LEN_W-1:0] cur_len;

   logic [LEN_W-1:0] span_len;
   logic             want;
   logic             fire;
   logic             bud_load;
   logic             bud_take;
   logic [BUD_W-1:0] bud_left;
   logic             bud_short;
   logic             bud_exact;
   logic             running;
   sg_desc_t         rsp;

   assign rsp = sg_desc_t'(mem_rdata);

   logic unused_bits;
   assign unused_bits = ^{rsp.rsvd, tbl_base[1:0]};

   sgdma_span #(
      .PAGE_BYTES (PAGE_BYTES),
      .CNT_W      (CNT_W),
      .LEN_W      (LEN_W)
   ) u_span (
      .pg_off (rg_addr[PG_W-1:0]),
      .left   (rg_left),
      .len    (span_len)
   );

   assign running = (st != ST_IDLE) && (st != ST_FIN) && (st != ST_FAIL);
   assign want    = ((st == ST_FETCH) || (st == ST_BURST)) && !abort;

   sgdma_retry #(
      .BACKOFF (BACKOFF)
   ) u_retry (
      .clk   (clk),
      .rst_n (rst_n),
      .want  (want),
      .busy  (mem_busy),
      .fire  (fire)
   );

   assign bud_load = (st == ST_IDLE) && arm;
   assign bud_take = (st == ST_BWAIT) && mem_ack && !abort && !bud_short;

   sgdma_budget #(
      .SCNT_W     (SCNT_W),
      .SECT_SHIFT (SECT_SHIFT),
      .LEN_W      (LEN_W),
      .BUD_W      (BUD_W)
   ) u_budget (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (bud_load),
      .scnt    (sect_cnt),
      .take    (bud_take),
      .len     (cur_len),
      .left    (bud_left),
      .short_o (bud_short),
      .exact_o (bud_exact)
   );

   // Memory request port
   assign mem_req   = fire;
   assign mem_desc  = (st == ST_FETCH);
   assign mem_wr    = (st == ST_BURST) && dir_q;
   assign mem_addr  = (st == ST_FETCH) ? tbl_ptr : rg_addr;
   assign mem_len   = (st == ST_FETCH) ? LEN_W'(DESC_BYTES) : span_len;
   assign xfer_done = (st == ST_FIN);
   assign xfer_err  = (st == ST_FAIL);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         tbl_ptr <= '0;
         rg_addr <= '0;
         rg_left <= '0;
         rg_last <= 1'b0;
         dly_q   <= '0;
         dir_q   <= 1'b0;
         cur_len <= '0;
      end else if (running && abort) begin
         st <= ST_FAIL;
      end else begin
         case (st)
            ST_IDLE: begin
               if (arm) begin
                  dir_q <= dir_to_mem;
                  st    <= ST_ARMED;
               end
            end
            ST_ARMED: begin
               if (go) begin
                  tbl_ptr <= {tbl_base[31:2], 2'b00};
                  st      <= ST_FETCH;
               end
            end
            ST_FETCH: begin
               if (fire) st <= ST_FWAIT;
            end
            ST_FWAIT: begin
               if (mem_ack) begin
                  rg_addr <= rsp.base;
                  rg_left <= rsp.nbytes;
                  rg_last <= rsp.last;
                  dly_q   <= DLY_W'(ACC_DELAY) + DLY_W'(rsp.nbytes >> SECT_SHIFT);
                  tbl_ptr <= tbl_ptr + 32'(DESC_BYTES);
                  st      <= ST_DELAY;
               end
            end
            ST_DELAY: begin
               if (dly_q == '0) st <= ST_BURST;
               else             dly_q <= dly_q - 1'b1;
            end
            ST_BURST: begin
               if (fire) begin
                  cur_len <= span_len;
                  st      <= ST_BWAIT;
               end
            end
            ST_BWAIT: begin
               if (mem_ack) begin
                  if (bud_short) begin
                     st <= ST_FAIL;
                  end else begin
                     rg_addr <= rg_addr + 32'(cur_len);
                     rg_left <= rg_left - CNT_W'(cur_len);
                     if (rg_left == CNT_W'(cur_len)) begin
                        if (rg_last) st <= bud_exact ? ST_FIN : ST_FAIL;
                        else         st <= ST_FETCH;
                     end else begin
                        st <= ST_BURST;
                     end
                  end
               end
            end
            ST_FIN:  st <= ST_IDLE;
            ST_FAIL: st <= ST_IDLE;
            default: st <= ST_IDLE;
         endcase
      end
   end

   // ---------------- assertions ----------------
   assert_req_not_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> !mem_busy);

   assert_page_fit_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_desc) |->
         ((int'(mem_addr[PG_W-1:0]) + int'(mem_len)) <= PAGE_BYTES));

   assert_table_align_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_desc) |-> (mem_addr[1:0] == 2'b00));

   assert_fetch_reads_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_desc) |-> !mem_wr);

   assert_done_budget_R8: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_done |-> (bud_left == '0));

   assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_done |=> !xfer_done);

   assert_abort_ends_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (abort && running) |=> (xfer_err && !mem_req));

   assert_single_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(xfer_done && xfer_err));

endmodule

// File: tb/tb_sg_desc_dma.sv
module tb_sg_desc_dma;

   localparam int PAGE = 8192;
   localparam int BO   = 4;
   localparam int ACC  = 3;
   localparam int LAT  = 1;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        arm = 1'b0;
   logic        dir_to_mem = 1'b0;
   logic [7:0]  sect_cnt = '0;
   logic        go = 1'b0;
   logic [31:0] tbl_base = '0;
   logic        abort = 1'b0;
   logic        mem_req, mem_desc, mem_wr;
   logic [31:0] mem_addr;
   logic [13:0] mem_len;
   logic        mem_busy = 1'b0;
   logic        mem_ack = 1'b0;
   logic [63:0] mem_rdata = '0;
   logic        xfer_done, xfer_err;

   always #4 clk = ~clk;   // 125 MHz

   sg_desc_dma #(
      .PAGE_BYTES (PAGE),
      .BACKOFF    (BO),
      .ACC_DELAY  (ACC)
   ) dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .arm        (arm),
      .dir_to_mem (dir_to_mem),
      .sect_cnt   (sect_cnt),
      .go         (go),
      .tbl_base   (tbl_base),
      .abort      (abort),
      .mem_req    (mem_req),
      .mem_desc   (mem_desc),
      .mem_wr     (mem_wr),
      .mem_addr   (mem_addr),
      .mem_len    (mem_len),
      .mem_busy   (mem_busy),
      .mem_ack    (mem_ack),
      .mem_rdata  (mem_rdata),
      .xfer_done  (xfer_done),
      .xfer_err   (xfer_err)
   );

   typedef struct {
      bit          desc;
      bit          wr;
      int unsigned addr;
      int unsigned len;
      string       tag;
   } req_t;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit summary_done = 0;

   req_t expq[$];
   logic [63:0] dtab [int unsigned];
   int unsigned d_addr [8];
   int unsigned d_cnt  [8];
   bit exp_done;

   int pend = 0;
   bit pend_desc = 0;
   logic [63:0] pend_data = '0;
   int done_cnt = 0, err_cnt = 0;
   int first_dack = -1, first_burst = -1, first_req = -1;
   int go_cyc = 0;

   task automatic chk(bit ok, string rq, string what, longint act, longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
      end
   endtask

   task automatic summary();
      if (!summary_done) begin
         summary_done = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #3;
   endtask

   // Memory responder: drives acknowledge a fixed latency after a request.
   initial begin
      forever begin
         @(posedge clk);
         #2;
         cyc++;
         mem_ack = 1'b0;
         if (pend > 0) begin
            pend--;
            if (pend == 0) begin
               mem_ack   = 1'b1;
               mem_rdata = pend_data;
               if (pend_desc && first_dack < 0) first_dack = cyc;
            end
         end
      end
   end

   // Monitor: compares every request with the reference queue.
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n) begin
            if (mem_req) begin
               req_t e;
               if (mem_busy) chk(0, "R6", "request while busy", 1, 0);
               if (expq.size() == 0) begin
                  chk(0, "R5", "unexpected request at address", longint'(mem_addr), 0);
               end else begin
                  e = expq.pop_front();
                  checks++;
                  if (mem_desc != e.desc || mem_wr != e.wr ||
                      mem_addr != e.addr || 32'(mem_len) != e.len) begin
                     errors++;
                     $display("FAIL %s request: actual desc=%0b wr=%0b addr=%h len=%0d expected desc=%0b wr=%0b addr=%h len=%0d",
                              e.tag, mem_desc, mem_wr, mem_addr, mem_len,
                              e.desc, e.wr, e.addr, e.len);
                  end
               end
               pend_desc = mem_desc;
               pend_data = dtab.exists(mem_addr) ? dtab[mem_addr] : 64'h0;
               pend = LAT;
               if (first_req < 0) first_req = cyc;
               if (!mem_desc && first_burst < 0) first_burst = cyc;
            end
            if (xfer_done) done_cnt++;
            if (xfer_err)  err_cnt++;
         end
      end
   end

   // Reference model: builds the expected request list and the outcome.
   task automatic build(int sec, bit dir, int unsigned base, int nd);
      int unsigned tb;
      longint bud;
      bit stop;
      tb = base & ~32'h3;
      bud = ((sec == 0) ? 256 : sec) * 512;
      stop = 0;
      expq.delete();
      dtab.delete();
      for (int i = 0; i < nd; i++) begin
         dtab[tb + 8 * i] = {(i == nd - 1) ? 1'b1 : 1'b0, 15'h0,
                             d_cnt[i][15:0], d_addr[i]};
      end
      for (int i = 0; i < nd; i++) begin
         int unsigned a, n;
         expq.push_back('{1'b1, 1'b0, tb + 8 * i, 8, "R3"});
         a = d_addr[i];
         n = d_cnt[i];
         while (n > 0 && !stop) begin
            int unsigned cap, room, len;
            cap  = (n > PAGE) ? PAGE : n;
            room = PAGE - (a % PAGE);
            len  = (cap >= room) ? room : cap;
            expq.push_back('{1'b0, dir, a, len, "R4 R5 R11"});
            if (bud < len) begin
               stop = 1;
            end else begin
               bud -= len;
               a += len;
               n -= len;
            end
         end
         if (stop) break;
      end
      exp_done = !stop && (bud == 0);
   endtask

   task automatic launch(int sec, bit dir, int unsigned base);
      done_cnt = 0;
      err_cnt = 0;
      first_dack = -1;
      first_burst = -1;
      first_req = -1;
      step();
      arm = 1'b1;
      sect_cnt = 8'(sec);
      dir_to_mem = dir;
      step();
      arm = 1'b0;
      go = 1'b1;
      tbl_base = base;
      go_cyc = cyc;
      step();
      go = 1'b0;
   endtask

   task automatic finish_cmd(string rq);
      for (int k = 0; k < 20000 && (done_cnt + err_cnt) == 0; k++) step();
      repeat (4) step();
      chk(done_cnt == (exp_done ? 1 : 0), rq, "done pulses", done_cnt, exp_done ? 1 : 0);
      chk(err_cnt == (exp_done ? 0 : 1), rq, "error pulses", err_cnt, exp_done ? 0 : 1);
      chk(expq.size() == 0, rq, "requests still expected", expq.size(), 0);
   endtask

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      chk(!mem_req && !xfer_done && !xfer_err, "R1", "outputs in reset",
          {mem_req, xfer_done, xfer_err}, 0);
      step();
      rst_n = 1'b1;
      repeat (5) step();
      chk(first_req < 0 && done_cnt == 0 && err_cnt == 0, "R1", "activity after reset",
          first_req, -1);

      // R3 R7 R8 R11: one region, unaligned table base, memory to buffer
      d_addr[0] = 32'h0000_4000; d_cnt[0] = 1024;
      build(2, 1'b0, 32'h0000_0103, 1);
      launch(2, 1'b0, 32'h0000_0103);
      finish_cmd("R8");
      chk(first_burst - first_dack == ACC + 2 + 2, "R7", "latency to first burst",
          first_burst - first_dack, ACC + 2 + 2);

      // R4 R5 R11: two regions crossing pages, buffer to memory
      d_addr[0] = 32'h0000_1F00; d_cnt[0] = 32'h600;
      d_addr[1] = 32'h0000_5000; d_cnt[1] = 32'h4200;
      build(36, 1'b1, 32'h0001_0000, 2);
      launch(36, 1'b1, 32'h0001_0000);
      finish_cmd("R5");

      // R2: sector count 0 buys 256 sectors, four page-aligned regions
      for (int i = 0; i < 4; i++) begin
         d_addr[i] = 32'h0010_0000 + i * 32'h0001_0000;
         d_cnt[i]  = 32'h8000;
      end
      build(0, 1'b0, 32'h0002_0000, 4);
      launch(0, 1'b0, 32'h0002_0000);
      finish_cmd("R2");

      // R9: burst larger than remaining budget
      d_addr[0] = 32'h0000_3000; d_cnt[0] = 1024;
      build(1, 1'b1, 32'h0003_0000, 1);
      launch(1, 1'b1, 32'h0003_0000);
      finish_cmd("R9");

      // R9: budget left over at the last entry
      build(4, 1'b0, 32'h0003_0000, 1);
      launch(4, 1'b0, 32'h0003_0000);
      finish_cmd("R9");

      // R6: busy port, retry spacing BO+1
      d_addr[0] = 32'h0000_6000; d_cnt[0] = 512;
      build(1, 1'b0, 32'h0004_0000, 1);
      mem_busy = 1'b1;
      launch(1, 1'b0, 32'h0004_0000);
      repeat (7) step();
      mem_busy = 1'b0;
      finish_cmd("R6");
      chk(first_req - go_cyc == 1 + (BO + 1) * 2, "R6", "first request after busy",
          first_req - go_cyc, 1 + (BO + 1) * 2);

      // R10: abort during the access latency
      d_addr[0] = 32'h0000_8000; d_cnt[0] = 4096;
      build(8, 1'b0, 32'h0005_0000, 1);
      while (expq.size() > 1) void'(expq.pop_back());
      exp_done = 0;
      launch(8, 1'b0, 32'h0005_0000);
      for (int k = 0; k < 100 && first_dack < 0; k++) step();
      repeat (2) step();
      abort = 1'b1;
      step();
      abort = 1'b0;
      repeat (40) step();
      finish_cmd("R10");

      // R10: abort while idle is ignored
      err_cnt = 0;
      abort = 1'b1;
      step();
      abort = 1'b0;
      repeat (5) step();
      chk(err_cnt == 0, "R10", "error pulse from idle abort", err_cnt, 0);

      // R10: abort while armed
      expq.delete();
      done_cnt = 0;
      err_cnt = 0;
      first_req = -1;
      step();
      arm = 1'b1;
      sect_cnt = 8'd1;
      step();
      arm = 1'b0;
      abort = 1'b1;
      step();
      abort = 1'b0;
      repeat (10) step();
      chk(err_cnt == 1, "R10", "error pulse from armed abort", err_cnt, 1);
      chk(first_req < 0, "R10", "requests after armed abort", first_req, -1);

      summary();
      $finish;
   end

   // Watchdog
   initial begin
      #(200000 * 8);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

endmodule